// File: doc/BRIEF.md
# Phase-Accumulating Sine Synthesiser with Two-Tone Keying and Quadrature Amplitude Control

The block is a numerically controlled oscillator that advances a 32-bit phase every clock by one of two tuning words, chosen per cycle by a keying input. This gives two-tone frequency keying without host involvement. A phase offset is added to the running phase. The top bits of the sum address a quarter-wave sine table, and symmetry logic rebuilds full-turn sine and cosine from it. Two signed amplitude factors, held as offset-binary fields in one modulation word, weight the cosine and the sine. The weighted terms are summed, rounded and clipped into a registered 10-bit two's-complement sample.

A host changes settings over a 16-bit write port. The two halves of a 32-bit value are first written into a staging word. A separate command then copies the whole staged word into one of four targets: tuning word 0, tuning word 1, phase offset, or modulation word. A target never holds a half-written value. A command can be accepted on every clock, so the tone, phase and amplitude can all be changed while the oscillator runs.

Top module: `dds_iq_mod`

## Requirements
- R1: A synchronous reset clears the accumulator, both tuning words, the phase offset, the staging word and the output sample. It loads the modulation word with both amplitude fields at midscale (0x02000200), and with that word the sample stays 0 while the phase runs.
- R2: On each clock out of reset the accumulator (`phase_o`) advances by tuning word 0 when `sel` is 0 and by tuning word 1 when `sel` is 1, wrapping modulo 2^32.
- R3: A write to address 0 loads the low 16 bits of the staging word, and a write to address 1 loads its high 16 bits. Neither write changes any target, so phase and sample stay as they were.
- R4: A write to address 2 with data bit 15 set copies the staging word into the target picked by data bits 1:0 (0 tuning word 0, 1 tuning word 1, 2 phase offset, 3 modulation word). The new target value is first used on the clock after the command.
- R5: A write to address 2 with data bit 15 clear, and any write to address 3, changes no register.
- R6: The table is addressed by bits 31:20 of the sum of accumulator and phase offset. Bits 31:30 give the quadrant, with cosine taken as the sine of that address plus 1024.
- R7: For a 12-bit address p, with h = p mod 2048, k = 2h+1, a = k(4096-k), the sine magnitude is floor(16·a·511 / (5·4096² − 4a)). It is negative when p ≥ 2048.
- R8: The modulation word carries I in bits 9:0 and Q in bits 25:16, each offset binary: the signed value is the field minus 512.
- R9: The sample registered on each clock is floor((I·cos + Q·sin + 256) / 512), computed from the accumulator, offset and modulation word present before that clock.
- R10: A result above 511 gives 511 and a result below −512 gives −512.
- R11: Commands on consecutive clocks are all applied, each on its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Keying input choosing the tuning word |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address: 0 low half, 1 high half, 2 command |
| wr_data | input | 16 | Host write data |
| phase_o | output | 32 | Accumulator value |
| sample_o | output | 10 | Output sample, two's complement |

## Verification
The bench builds the block with its default parameters: a 16-bit host port (hence a 32-bit accumulator), a 1024-entry quarter table and 10-bit amplitude and sample widths. At these sizes a tuning word of 0x00100000 steps the table address by one per clock, so every table entry in all four quadrants is reached within 4096 cycles. A tuning word near 2^32 drives the accumulator through its wrap within a few clocks. With both amplitude fields at their extreme the weighted sum reaches about ±724, which takes the clipping to both rails.

// File: rtl/dds_iq_mod.sv
module dds_iq_mod #(
  parameter int BUS_W  = 16,
  parameter int LUT_AW = 10,
  parameter int OUT_W  = 10,
  parameter int AMP_W  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [BUS_W-1:0]   wr_data,
  output logic [2*BUS_W-1:0] phase_o,
  output logic [OUT_W-1:0]   sample_o
);
  localparam int ACC_W  = 2 * BUS_W;
  localparam int PH_W   = LUT_AW + 2;
  localparam int QN     = 1 << LUT_AW;
  localparam int SPAN   = 1 << PH_W;
  localparam int MAG_W  = OUT_W - 1;
  localparam int PEAK   = (1 << (OUT_W - 1)) - 1;
  localparam int PROD_W = OUT_W + AMP_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int SHIFT  = AMP_W - 1;
  localparam int Q_LSB  = BUS_W;
  localparam logic [ACC_W-1:0] IQ_ZERO =
    ACC_W'((longint'(1) << (AMP_W - 1)) | (longint'(1) << (AMP_W - 1 + Q_LSB)));
  localparam logic signed [SUM_W-1:0] RND_HALF = SUM_W'(1 << (SHIFT - 1));
  localparam logic signed [SUM_W-1:0] HI = SUM_W'(PEAK);
  localparam logic signed [SUM_W-1:0] LO = SUM_W'(-(PEAK + 1));

  function automatic logic [MAG_W-1:0] qsin(input int k);
    longint kk, a, v;
    kk = 2 * longint'(k) + 1;
    a  = kk * (longint'(SPAN) - kk);
    v  = (16 * a * PEAK) / (5 * longint'(SPAN) * longint'(SPAN) - 4 * a);
    return MAG_W'(v);
  endfunction

  logic [MAG_W-1:0] rom [QN];
  for (genvar g = 0; g < QN; g++) begin : g_rom
    assign rom[g] = qsin(g);
  end

  logic [ACC_W-1:0] acc_q, frq0_q, frq1_q, off_q, iq_q, stage_q;

  logic [ACC_W-1:0]  ph_sum;
  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx;
  assign ph_sum = acc_q + off_q;
  assign quad   = ph_sum[ACC_W-1 -: 2];
  assign idx    = ph_sum[ACC_W-3 -: LUT_AW];

  logic [MAG_W-1:0] sin_mag, cos_mag;
  assign sin_mag = rom[quad[0] ? ~idx : idx];
  assign cos_mag = rom[quad[0] ? idx : ~idx];

  logic signed [OUT_W-1:0] sin_v, cos_v;
  assign sin_v = quad[1] ? -$signed({1'b0, sin_mag}) : $signed({1'b0, sin_mag});
  assign cos_v = (quad[1] ^ quad[0]) ? -$signed({1'b0, cos_mag}) : $signed({1'b0, cos_mag});

  logic signed [AMP_W-1:0] i_v, q_v;
  assign i_v = $signed({~iq_q[AMP_W-1], iq_q[AMP_W-2:0]});
  assign q_v = $signed({~iq_q[Q_LSB+AMP_W-1], iq_q[Q_LSB +: AMP_W-1]});

  logic signed [PROD_W-1:0] p_i, p_q;
  assign p_i = PROD_W'(i_v) * PROD_W'(cos_v);
  assign p_q = PROD_W'(q_v) * PROD_W'(sin_v);

  logic signed [SUM_W-1:0] mix, rnd, scaled;
  assign mix    = $signed({p_i[PROD_W-1], p_i}) + $signed({p_q[PROD_W-1], p_q});
  assign rnd    = mix + RND_HALF;
  assign scaled = rnd >>> SHIFT;

  logic [OUT_W-1:0] clip;
  assign clip = (scaled > HI) ? HI[OUT_W-1:0] :
                (scaled < LO) ? LO[OUT_W-1:0] : scaled[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      frq0_q   <= '0;
      frq1_q   <= '0;
      off_q    <= '0;
      stage_q  <= '0;
      iq_q     <= IQ_ZERO;
      sample_o <= '0;
    end else begin
      acc_q    <= acc_q + (sel ? frq1_q : frq0_q);
      sample_o <= clip;
      if (wr_en) begin
        case (wr_addr)
          2'd0: stage_q[BUS_W-1:0]     <= wr_data;
          2'd1: stage_q[ACC_W-1:BUS_W] <= wr_data;
          2'd2: if (wr_data[BUS_W-1]) begin
            case (wr_data[1:0])
              2'd0: frq0_q <= stage_q;
              2'd1: frq1_q <= stage_q;
              2'd2: off_q  <= stage_q;
              default: iq_q <= stage_q;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assign phase_o = acc_q;
endmodule

// File: rtl/dds_iq_mod_chk.sv
module dds_iq_mod_chk #(
  parameter int BUS_W = 16,
  parameter int OUT_W = 10,
  parameter int AMP_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               sel,
  input logic               wr_en,
  input logic [1:0]         wr_addr,
  input logic [BUS_W-1:0]   wr_data,
  input logic [2*BUS_W-1:0] acc_q,
  input logic [2*BUS_W-1:0] frq0_q,
  input logic [2*BUS_W-1:0] frq1_q,
  input logic [2*BUS_W-1:0] off_q,
  input logic [2*BUS_W-1:0] iq_q,
  input logic [2*BUS_W-1:0] stage_q,
  input logic [OUT_W-1:0]   sample_o
);
  localparam logic [2*BUS_W-1:0] MID =
    (2*BUS_W)'((longint'(1) << (AMP_W - 1)) | (longint'(1) << (AMP_W - 1 + BUS_W)));

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_iq_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (iq_q == MID && acc_q == '0));

  assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
    armed |-> acc_q == $past(acc_q) + ($past(sel) ? $past(frq1_q) : $past(frq0_q)));

  assert_half_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[1]) |=>
      ($stable(frq0_q) && $stable(frq1_q) && $stable(off_q) && $stable(iq_q)));

  assert_commit_f0_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd2 && wr_data[BUS_W-1] && wr_data[1:0] == 2'd0) |=>
      frq0_q == $past(stage_q));

  assert_commit_iq_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd2 && wr_data[BUS_W-1] && wr_data[1:0] == 2'd3) |=>
      iq_q == $past(stage_q));

  assert_ignored_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[1] && (wr_addr[0] || !wr_data[BUS_W-1])) |=>
      ($stable(frq0_q) && $stable(frq1_q) && $stable(off_q) && $stable(iq_q) && $stable(stage_q)));

  assert_zero_amp_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && iq_q == MID) |=> sample_o == '0);
endmodule

bind dds_iq_mod dds_iq_mod_chk #(.BUS_W(BUS_W), .OUT_W(OUT_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .acc_q(acc_q), .frq0_q(frq0_q), .frq1_q(frq1_q), .off_q(off_q), .iq_q(iq_q),
  .stage_q(stage_q), .sample_o(sample_o)
);

// File: tb/dds_iq_mod_bench.sv
module dds_iq_mod_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [31:0] phase_o;
  logic [9:0] sample_o;

  always #(CLK_NS/2) clk = ~clk;

  dds_iq_mod u_dds_iq_mod (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .phase_o(phase_o), .sample_o(sample_o)
  );

  int nchk = 0;
  int nbad = 0;
  bit done = 0;
  string tag = "R1";
  int seen_max = -10000;
  int seen_min = 10000;

  task automatic chk(input string t, input string what, input longint got, input longint exp);
    nchk++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s %s got=%0d exp=%0d", t, what, got, exp);
    end
  endtask

  function automatic int wave(input int p);
    int h;
    longint kk, a, v;
    h  = p % 2048;
    kk = 2 * longint'(h) + 1;
    a  = kk * (4096 - kk);
    v  = (16 * a * 511) / (5 * longint'(4096) * 4096 - 4 * a);
    return (p >= 2048) ? -int'(v) : int'(v);
  endfunction

  function automatic int ref_sample(input logic [31:0] acc, input logic [31:0] off,
                                    input logic [31:0] iq);
    logic [31:0] t;
    int p, c, s, iv, qv;
    longint sum, r;
    t  = acc + off;
    p  = int'(t[31:20]);
    c  = wave((p + 1024) % 4096);
    s  = wave(p);
    iv = int'(iq[9:0]) - 512;
    qv = int'(iq[25:16]) - 512;
    sum = longint'(iv) * c + longint'(qv) * s + 256;
    r = (sum >= 0) ? sum / 512 : -((-sum + 511) / 512);
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return int'(r);
  endfunction

  logic [31:0] m_acc, m_f0, m_f1, m_off, m_iq, m_stage;
  int m_out;

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_f0 = 0; m_f1 = 0; m_off = 0; m_stage = 0;
      m_iq = 32'h0200_0200; m_out = 0;
    end else begin
      m_out = ref_sample(m_acc, m_off, m_iq);
      m_acc = m_acc + (sel ? m_f1 : m_f0);
      if (wr_en) begin
        if (wr_addr == 2'd0) m_stage[15:0] = wr_data;
        else if (wr_addr == 2'd1) m_stage[31:16] = wr_data;
        else if (wr_addr == 2'd2 && wr_data[15]) begin
          if (wr_data[1:0] == 2'd0) m_f0 = m_stage;
          else if (wr_data[1:0] == 2'd1) m_f1 = m_stage;
          else if (wr_data[1:0] == 2'd2) m_off = m_stage;
          else m_iq = m_stage;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, "phase_o", longint'(phase_o), longint'(m_acc));
      chk(tag, "sample_o", longint'($signed(sample_o)), longint'(m_out));
      if (int'($signed(sample_o)) > seen_max) seen_max = int'($signed(sample_o));
      if (int'($signed(sample_o)) < seen_min) seen_min = int'($signed(sample_o));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put32(input logic [31:0] v);
    wr(2'd0, v[15:0]);
    wr(2'd1, v[31:16]);
  endtask

  task automatic commit(input logic [1:0] target);
    wr(2'd2, {14'h2000, target});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset phase_o", longint'(phase_o), 0);
    chk("R1", "reset sample_o", longint'(sample_o), 0);
    rst = 1'b0;

    tag = "R4";
    put32(32'h00C0_FFEE); commit(2'd0);
    tag = "R1";
    idle(20);

    tag = "R8";
    put32(32'h0200_03FF); commit(2'd3); idle(30);
    put32(32'h03FF_0200); commit(3); idle(30);
    put32(32'h0200_0000); commit(3); idle(30);

    tag = "R2";
    put32(32'h1000_0000); commit(2'd1);
    sel = 1'b1; idle(10);
    sel = 1'b0; idle(10);
    for (int i = 0; i < 12; i++) begin sel = i[0]; idle(1); end
    sel = 1'b0;
    put32(32'hFFFF_F000); commit(2'd0); idle(10);
    put32(32'hF000_0000); commit(2'd0); idle(10);

    tag = "R3";
    put32(32'h1234_5678); idle(10);

    tag = "R5";
    wr(2'd2, 16'h0000); wr(2'd2, 16'h0003); wr(2'd3, 16'h8000); idle(10);

    tag = "R6";
    put32(32'h0); commit(2'd0);
    put32(32'h0200_03FF); commit(2'd3); idle(3);
    put32(32'h4000_0000); commit(2'd2); idle(4);
    put32(32'h8000_0000); commit(2'd2); idle(4);
    put32(32'h0123_4567); commit(2'd2); idle(4);
    put32(32'h0); commit(2'd2);

    tag = "R7";
    put32(32'h0010_0000); commit(2'd0); idle(4100);
    put32(32'h03FF_0200); commit(2'd3); idle(4100);

    tag = "R9";
    put32(32'h0100_0300); commit(2'd3); idle(300);
    put32(32'h0250_0190); commit(2'd3); idle(300);

    tag = "R10";
    put32(32'h0000_0000); commit(2'd3);
    idle(2);
    seen_max = -10000; seen_min = 10000;
    idle(4100);
    chk("R10", "top rail", seen_max, 511);
    chk("R10", "bottom rail", seen_min, -512);

    tag = "R11";
    put32(32'h0020_0000);
    commit(2'd0); commit(2'd1); commit(2'd2); commit(2'd3);
    sel = 1'b1; idle(10);
    put32(32'h0300_0100);
    commit(2'd3); commit(2'd0); idle(20);

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL R11 watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule